// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a byte-addressed serial nonvolatile memory with 4096 locations. It watches chip select, serial clock, serial input and a hold input, all oversampled on a system clock that runs at least eight times faster than the serial clock. Each frame starts with a one-byte opcode. The opcode may be followed by a two-byte address and by data. Bits arrive most significant first on rising serial-clock edges. Output bits leave on falling edges, so serial clock modes 0 and 3 both work.

The block does not hold the cells or the protection logic. It reads the array through a registered read port. Write data goes to a 32-byte page buffer one byte at a time, and a page commit strobe is issued only when a write frame closes cleanly. Enable, disable and status-write requests go out as strobes to the status unit. That unit supplies the status byte and a busy flag. A frame that is cut short or badly formed leaves no trace on the commit strobes.

Top module: `spi_nvm_frontend`

## Requirements
- R1: While chip select is high, or within a few system clocks of its rising edge, so_oe_o is 0. After reset no strobe is active.
- R2: Opcode 8'h06 gives exactly one wren_o pulse and opcode 8'h04 gives exactly one wrdi_o pulse. Opcode bits are taken MSB first on rising serial-clock edges.
- R3: Opcode 8'h03 is followed by an address high byte and then a low byte. Bits 15..12 are ignored, so rd_addr_o equals address bits 11..0. Data bit 7 is driven after the falling edge that follows the 24th rising edge, and the remaining bits follow MSB first.
- R4: During a read, each further byte comes from the next address. After address 12'hFFF the next byte comes from 12'h000.
- R5: Opcode 8'h05 makes so_o shift out status_i, bit 7 first. The byte repeats for as long as the clock keeps running.
- R6: After opcode 8'h02 and the address, each full data byte gives one pb_we_o pulse. pb_idx_o carries address bits 4..0, which count up modulo 32. If chip select then rises on a byte boundary with at least one data byte, pg_commit_o pulses once and pg_base_o carries address bits 11..5.
- R7: A write frame whose chip-select rise falls off a byte boundary, or that carries no data byte, gives no pg_commit_o.
- R8: Opcode 8'h01 with exactly one data byte, ended on a byte boundary, gives one sr_we_o pulse and sr_data_o holds that byte. Two or more data bytes, or an off-boundary end, give no sr_we_o.
- R9: A falling hold_n_i while the serial clock is low suspends the frame. During the suspension so_oe_o is 0 and serial-clock edges and serial input are ignored. A rising hold_n_i resumes the frame where it stopped.
- R10: While busy_i is high at opcode completion, every opcode except 8'h05 is ignored and gives no strobe. Opcode 8'h05 still works.
- R11: A chip-select rise ends the frame and clears hold, so the next frame starts again at its opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Hold request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o; 0 means high impedance |
| busy_i | input | 1 | Internal write in progress |
| status_i | input | 8 | Status byte returned by opcode 05h |
| rd_addr_o | output | 12 | Array read address |
| rd_data_i | input | 8 | Array data, valid one clock after rd_addr_o |
| wren_o | output | 1 | Write-enable request strobe |
| wrdi_o | output | 1 | Write-disable request strobe |
| pb_we_o | output | 1 | Page-buffer byte strobe |
| pb_idx_o | output | 5 | Byte index within the page |
| pb_data_o | output | 8 | Page-buffer byte |
| pg_commit_o | output | 1 | Commit the page buffer |
| pg_base_o | output | 7 | Page number for the commit |
| sr_we_o | output | 1 | Status-write request strobe |
| sr_data_o | output | 8 | Status-write data |

## Verification
The bench reads across the top of the array. A design that saturated at 12'hFFF, or carried into the ignored upper bits, would return the wrong third byte. It starts a page write at index 30, so a pointer that carried into the page number would commit the wrong page or scatter the bytes. It also ends write and status-write frames a few bits past a byte boundary and sends status writes with two data bytes. A design that counted bytes instead of checking the boundary would commit data it should drop. Finally, it holds a read in the middle of a byte while toggling the clock, and it aborts a frame while hold is still asserted. A design that let edges through during hold, or kept hold across chip select, would return shifted data or miss the next opcode.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam int BW = 8;
  localparam logic [BW-1:0] OP_WREN  = 8'h06;
  localparam logic [BW-1:0] OP_WRDI  = 8'h04;
  localparam logic [BW-1:0] OP_RDSR  = 8'h05;
  localparam logic [BW-1:0] OP_WRSR  = 8'h01;
  localparam logic [BW-1:0] OP_READ  = 8'h03;
  localparam logic [BW-1:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_RDAT, PH_STAT, PH_WDAT, PH_SDAT, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_nvm_frame.sv
module spi_nvm_frame
  import spi_nvm_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sck_s,
  input  logic             si_s,
  input  logic             hold_s,
  input  logic             busy_i,
  output logic             held,
  output logic             cs_rise_evt,
  output logic             fall_evt,
  output logic             out_phase,
  output logic             stat_src,
  output logic             load_now,
  output logic             rd_next_evt,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wren_o,
  output logic             wrdi_o,
  output logic             pb_we_o,
  output logic [PW-1:0]    pb_idx_o,
  output logic [BW-1:0]    pb_data_o,
  output logic             pg_commit_o,
  output logic [AW-PW-1:0] pg_base_o,
  output logic             sr_we_o,
  output logic [BW-1:0]    sr_data_o
);
  function automatic logic [AW-1:0] next_rd(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] next_pg(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + 1'b1};
  endfunction

  logic          sck_q, cs_q, hold_q, held_q, wr_mode, have_data, ld_p1;
  logic [2:0]    bit_cnt;
  logic [1:0]    sr_cnt;
  logic [BW-2:0] shreg;
  logic [AW-1:0] wptr;
  phase_t        phase;

  wire          act      = ~cs_s & ~held_q;
  wire          bit_evt  = act & sck_s & ~sck_q;
  wire [BW-1:0] byte_in  = {shreg, si_s};
  wire          byte_evt = bit_evt & (bit_cnt == 3'd7);
  wire          op_ok    = ~busy_i | (byte_in == OP_RDSR);
  wire          load_evt = byte_evt & ((phase == PH_ALO & ~wr_mode) | phase == PH_RDAT
                                       | phase == PH_STAT | (phase == PH_OPC & byte_in == OP_RDSR));

  assign held        = held_q;
  assign cs_rise_evt = cs_s & ~cs_q;
  assign fall_evt    = act & ~sck_s & sck_q;
  assign out_phase   = (phase == PH_RDAT) | (phase == PH_STAT);
  assign stat_src    = (phase == PH_STAT);
  assign rd_next_evt = byte_evt & (phase == PH_RDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; hold_q <= 1'b1; held_q <= 1'b0;
      phase <= PH_OPC; bit_cnt <= '0; shreg <= '0; wptr <= '0; wr_mode <= 1'b0;
      have_data <= 1'b0; sr_cnt <= '0; ld_p1 <= 1'b0; load_now <= 1'b0;
      rd_addr_o <= '0; wren_o <= 1'b0; wrdi_o <= 1'b0; pb_we_o <= 1'b0;
      pb_idx_o <= '0; pb_data_o <= '0; pg_commit_o <= 1'b0; pg_base_o <= '0;
      sr_we_o <= 1'b0; sr_data_o <= '0;
    end else begin
      sck_q    <= sck_s;
      cs_q     <= cs_s;
      hold_q   <= hold_s;
      ld_p1    <= load_evt;
      load_now <= ld_p1;
      wren_o   <= 1'b0;
      wrdi_o   <= 1'b0;
      pb_we_o  <= 1'b0;
      pg_commit_o <= cs_rise_evt & (phase == PH_WDAT) & (bit_cnt == 3'd0) & have_data;
      sr_we_o     <= cs_rise_evt & (phase == PH_SDAT) & (bit_cnt == 3'd0) & (sr_cnt == 2'd1);
      if (cs_rise_evt) pg_base_o <= wptr[AW-1:PW];

      if (cs_s) held_q <= 1'b0;
      else if (~hold_s & hold_q & ~sck_s) held_q <= 1'b1;
      else if (hold_s & ~hold_q) held_q <= 1'b0;

      if (cs_s) begin
        phase <= PH_OPC; bit_cnt <= '0; wr_mode <= 1'b0; have_data <= 1'b0; sr_cnt <= '0;
      end else if (bit_evt) begin
        shreg   <= byte_in[BW-2:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_OPC: begin
              phase <= PH_SKIP;
              if (op_ok) begin
                case (byte_in)
                  OP_WREN:  wren_o <= 1'b1;
                  OP_WRDI:  wrdi_o <= 1'b1;
                  OP_RDSR:  phase <= PH_STAT;
                  OP_WRSR:  phase <= PH_SDAT;
                  OP_READ:  phase <= PH_AHI;
                  OP_WRITE: begin phase <= PH_AHI; wr_mode <= 1'b1; end
                  default:  phase <= PH_SKIP;
                endcase
              end
            end
            PH_AHI: begin
              wptr[AW-1:BW] <= byte_in[AW-BW-1:0];
              phase <= PH_ALO;
            end
            PH_ALO: begin
              wptr[BW-1:0] <= byte_in;
              rd_addr_o    <= {wptr[AW-1:BW], byte_in};
              phase        <= wr_mode ? PH_WDAT : PH_RDAT;
            end
            PH_RDAT: rd_addr_o <= next_rd(rd_addr_o);
            PH_WDAT: begin
              pb_we_o   <= 1'b1;
              pb_idx_o  <= wptr[PW-1:0];
              pb_data_o <= byte_in;
              wptr      <= next_pg(wptr);
              have_data <= 1'b1;
            end
            PH_SDAT: begin
              if (sr_cnt == 2'd0) sr_data_o <= byte_in;
              if (sr_cnt != 2'd2) sr_cnt <= sr_cnt + 2'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvm_shift.sv
module spi_nvm_shift
  import spi_nvm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          held,
  input  logic          fall_evt,
  input  logic          out_phase,
  input  logic          load_now,
  input  logic [BW-1:0] load_val,
  output logic          so_o,
  output logic          so_oe_o
);
  logic [BW-1:0] osr;
  logic          out_on;
  wire           shift_evt = fall_evt & out_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr <= '0; so_o <= 1'b0; out_on <= 1'b0; so_oe_o <= 1'b0;
    end else begin
      if (load_now) osr <= load_val;
      else if (shift_evt) begin
        so_o <= osr[BW-1];
        osr  <= {osr[BW-2:0], 1'b0};
      end
      if (cs_s) out_on <= 1'b0;
      else if (shift_evt) out_on <= 1'b1;
      so_oe_o <= ~cs_s & ~held & (out_on | shift_evt);
    end
  end
endmodule

// File: rtl/spi_nvm_frontend.sv
module spi_nvm_frontend
  import spi_nvm_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             si_i,
  input  logic             hold_n_i,
  output logic             so_o,
  output logic             so_oe_o,
  input  logic             busy_i,
  input  logic [BW-1:0]    status_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [BW-1:0]    rd_data_i,
  output logic             wren_o,
  output logic             wrdi_o,
  output logic             pb_we_o,
  output logic [PW-1:0]    pb_idx_o,
  output logic [BW-1:0]    pb_data_o,
  output logic             pg_commit_o,
  output logic [AW-PW-1:0] pg_base_o,
  output logic             sr_we_o,
  output logic [BW-1:0]    sr_data_o
);
  localparam int NPIN = 4;
  logic [NPIN-1:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s;
  logic held, cs_rise_evt, fall_evt, out_phase, stat_src, load_now, rd_next_evt;

  spi_nvm_sync #(.W(NPIN), .INIT(4'b1001)) u_sync (
    .clk, .rst_n, .d({cs_n_i, sck_i, si_i, hold_n_i}), .q(pins_s)
  );
  assign {cs_s, sck_s, si_s, hold_s} = pins_s;

  spi_nvm_frame #(.AW(AW), .PW(PW)) u_frame (
    .clk, .rst_n, .cs_s, .sck_s, .si_s, .hold_s, .busy_i,
    .held, .cs_rise_evt, .fall_evt, .out_phase, .stat_src, .load_now, .rd_next_evt,
    .rd_addr_o, .wren_o, .wrdi_o, .pb_we_o, .pb_idx_o, .pb_data_o,
    .pg_commit_o, .pg_base_o, .sr_we_o, .sr_data_o
  );

  spi_nvm_shift u_shift (
    .clk, .rst_n, .cs_s, .held, .fall_evt, .out_phase, .load_now,
    .load_val(stat_src ? status_i : rd_data_i),
    .so_o, .so_oe_o
  );
endmodule

// File: rtl/spi_nvm_chk.sv
module spi_nvm_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          held,
  input logic          cs_rise_evt,
  input logic          rd_next_evt,
  input logic          busy_i,
  input logic          so_oe_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wren_o,
  input logic          wrdi_o,
  input logic          pb_we_o,
  input logic          pg_commit_o,
  input logic          sr_we_o
);
  // R1
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !so_oe_o);
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_o, wrdi_o, pb_we_o, pg_commit_o, sr_we_o}));
  // R4
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next_evt && rd_addr_o == {AW{1'b1}}) |=> rd_addr_o == '0);
  // R6
  commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_commit_o |-> $past(cs_rise_evt));
  // R8
  srw_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we_o |-> $past(cs_rise_evt));
  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) held |=> !so_oe_o);
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> (!wren_o && !wrdi_o));
  // R11
  cs_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> !held);
endmodule

bind spi_nvm_frontend spi_nvm_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .held(held), .cs_rise_evt(cs_rise_evt),
  .rd_next_evt(rd_next_evt), .busy_i(busy_i), .so_oe_o(so_oe_o), .rd_addr_o(rd_addr_o),
  .wren_o(wren_o), .wrdi_o(wrdi_o), .pb_we_o(pb_we_o), .pg_commit_o(pg_commit_o),
  .sr_we_o(sr_we_o)
);

// File: tb/spi_nvm_frontend_bench.sv
module spi_nvm_frontend_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status = 8'h00, rd_data = 8'h00;
  logic so, so_oe, wren, wrdi, pb_we, pg_commit, sr_we;
  logic [11:0] rd_addr;
  logic [4:0] pb_idx;
  logic [7:0] pb_data, sr_data;
  logic [6:0] pg_base;
  logic [7:0] mem [4096];
  int n_chk = 0, n_err = 0;
  int n_wren = 0, n_wrdi = 0, n_pb = 0, n_commit = 0, n_sr = 0;
  logic [4:0] pb_idx_log [40];
  logic [7:0] pb_dat_log [40];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nvm_frontend u_spi_nvm_frontend (
    .clk, .rst_n, .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .status_i(status),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wren_o(wren), .wrdi_o(wrdi),
    .pb_we_o(pb_we), .pb_idx_o(pb_idx), .pb_data_o(pb_data),
    .pg_commit_o(pg_commit), .pg_base_o(pg_base), .sr_we_o(sr_we), .sr_data_o(sr_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 4));
  endfunction

  initial for (int i = 0; i < 4096; i++) mem[i] = pat(i);
  always @(posedge clk) rd_data <= mem[rd_addr];

  always @(posedge clk) begin
    if (wren) n_wren++;
    if (wrdi) n_wrdi++;
    if (sr_we) n_sr++;
    if (pg_commit) n_commit++;
    if (pb_we) begin
      if (n_pb < 40) begin pb_idx_log[n_pb] = pb_idx; pb_dat_log[n_pb] = pb_data; end
      n_pb++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_wren = 0; n_wrdi = 0; n_pb = 0; n_commit = 0; n_sr = 0;
  endtask

  task automatic start(input bit mode3);
    sck = mode3; #HALF; cs_n = 1'b0; #HALF;
  endtask

  task automatic stop();
    if (sck) begin sck = 1'b0; #HALF; end
    cs_n = 1'b1; #(4 * HALF);
  endtask

  task automatic shift_bits(input int n, input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; si = tx[7-i]; #HALF;
      rx = {rx[6:0], so};
      sck = 1'b1; #HALF;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    shift_bits(8, tx, rx);
  endtask

  task automatic t_reset();
    #(3 * HALF);
    chk(so_oe === 1'b0, "R1", "so_oe after reset", so_oe, 0);
    chk(n_wren + n_wrdi + n_pb + n_commit + n_sr == 0, "R1", "strobes after reset", n_wren + n_pb, 0);
  endtask

  task automatic t_enable();
    logic [7:0] rx;
    clear_counts();
    start(0); xfer(8'h06, rx); stop();
    chk(n_wren == 1 && n_wrdi == 0, "R2", "wren pulses", n_wren, 1);
    start(1); xfer(8'h04, rx); stop();
    chk(n_wrdi == 1 && n_wren == 1, "R2", "wrdi pulses", n_wrdi, 1);
    chk(so_oe === 1'b0, "R1", "so_oe with cs high", so_oe, 0);
  endtask

  task automatic t_read(input bit mode3, input logic [15:0] a, input int nb, input string req);
    logic [7:0] rx;
    int base;
    base = int'(a[11:0]);
    start(mode3); xfer(8'h03, rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
    for (int k = 0; k < nb; k++) begin
      xfer(8'h00, rx);
      chk(rx == pat((base + k) % 4096), req, $sformatf("read byte %0d", k), rx, pat((base + k) % 4096));
    end
    chk(so_oe === 1'b1, "R3", "so_oe during read", so_oe, 1);
    stop();
    chk(so_oe === 1'b0, "R1", "so_oe after read", so_oe, 0);
  endtask

  task automatic t_status(input bit mode3, input logic [7:0] sv, input string req);
    logic [7:0] rx;
    status = sv;
    start(mode3); xfer(8'h05, rx);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx);
      chk(rx == sv, req, $sformatf("status repeat %0d", k), rx, sv);
    end
    stop();
  endtask

  task automatic t_write();
    logic [7:0] rx;
    clear_counts();
    start(0); xfer(8'h02, rx); xfer(8'hA0, rx); xfer(8'h3E, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); stop();
    chk(n_pb == 3, "R6", "page byte strobes", n_pb, 3);
    chk(pb_idx_log[0] == 5'd30 && pb_idx_log[1] == 5'd31 && pb_idx_log[2] == 5'd0,
        "R6", "page index wrap", pb_idx_log[2], 0);
    chk(pb_dat_log[0] == 8'h11 && pb_dat_log[2] == 8'h33, "R6", "page data", pb_dat_log[2], 8'h33);
    chk(n_commit == 1 && pg_base == 7'd1, "R6", "commit page", pg_base, 1);
  endtask

  task automatic t_write_bad();
    logic [7:0] rx;
    clear_counts();
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h40, rx);
    xfer(8'h55, rx); shift_bits(3, 8'hFF, rx); stop();
    chk(n_commit == 0, "R7", "commit after off-boundary end", n_commit, 0);
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h40, rx); stop();
    chk(n_commit == 0, "R7", "commit with no data", n_commit, 0);
  endtask

  task automatic t_status_write();
    logic [7:0] rx;
    clear_counts();
    start(0); xfer(8'h01, rx); xfer(8'h5C, rx); stop();
    chk(n_sr == 1 && sr_data == 8'h5C, "R8", "status write one byte", sr_data, 8'h5C);
    start(0); xfer(8'h01, rx); xfer(8'h5C, rx); xfer(8'h11, rx); stop();
    chk(n_sr == 1, "R8", "status write two bytes", n_sr, 1);
    start(1); xfer(8'h01, rx); xfer(8'h5C, rx); shift_bits(4, 8'h00, rx); stop();
    chk(n_sr == 1, "R8", "status write off boundary", n_sr, 1);
  endtask

  task automatic t_hold();
    logic [7:0] rx, hi, lo;
    start(0); xfer(8'h03, rx); xfer(8'h01, rx); xfer(8'h00, rx);
    xfer(8'h00, rx);
    chk(rx == pat(12'h100), "R9", "byte before hold", rx, pat(12'h100));
    shift_bits(4, 8'h00, hi);
    sck = 1'b0; #HALF;
    hold_n = 1'b0; #(2 * HALF);
    chk(so_oe === 1'b0, "R9", "so_oe during hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin si = k[0]; sck = 1'b1; #HALF; sck = 1'b0; #HALF; end
    hold_n = 1'b1; #HALF;
    shift_bits(4, 8'h00, lo);
    chk({hi[3:0], lo[3:0]} == pat(12'h101), "R9", "byte across hold", {hi[3:0], lo[3:0]}, pat(12'h101));
    xfer(8'h00, rx);
    chk(rx == pat(12'h102), "R9", "byte after hold", rx, pat(12'h102));
    stop();
  endtask

  task automatic t_busy();
    logic [7:0] rx;
    clear_counts();
    busy = 1'b1;
    start(0); xfer(8'h06, rx); stop();
    chk(n_wren == 0, "R10", "wren while busy", n_wren, 0);
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h77, rx); stop();
    chk(n_pb == 0 && n_commit == 0, "R10", "write while busy", n_pb + n_commit, 0);
    t_status(0, 8'h01, "R10");
    busy = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    clear_counts();
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); shift_bits(5, 8'h00, rx); stop();
    start(0); xfer(8'h03, rx); shift_bits(3, 8'h00, rx);
    sck = 1'b0; #HALF; hold_n = 1'b0; #HALF;
    cs_n = 1'b1; #(2 * HALF); hold_n = 1'b1; #(2 * HALF);
    start(0); xfer(8'h06, rx); stop();
    chk(n_wren == 1 && n_commit == 0, "R11", "fresh opcode after abort", n_wren, 1);
  endtask

  initial begin
    #(5 * CLK_PERIOD + 2);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_read(0, 16'h1234, 3, "R3");
    t_read(1, 16'hFFFE, 3, "R4");
    t_status(1, 8'hA6, "R5");
    t_status(0, 8'h3C, "R5");
    t_write();
    t_write_bad();
    t_status_write();
    t_hold();
    t_busy();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(100000 * CLK_PERIOD);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule